// File: doc/BRIEF.md
# GPIO port with alert logic

This block is a register-mapped general-purpose I/O controller with two 8-bit ports. A simple synchronous bus accesses the registers. A write takes effect on the clock edge where the request is sampled, and read data is combinational from the address. Each access covers one byte. With the wide flag set it covers two adjacent bytes, the higher address on the upper data lane.

Each pin has:
- an output latch,
- a direction bit,
- a push-pull or open-drain selector,
- a synchronized input reading.

Each pin also has its own alert detector. Two independent enables select rising-edge and falling-edge detection. When neither edge enable is set, the pin is in level mode, and a level bit picks whether high or low is the active level. Detected alerts set sticky status bits that software clears by writing ones. Masked status feeds a summary flag. The summary flag is held by a small state machine in a top-level alert register, and that register is gated by a top-level mask onto the alert output.

Port 0 pins are shared with alternate functions, and a mux register hands each pin to GPIO use. A parameter selects a reduced variant. In that variant only a subset of port 0 exists, and all port 1 accesses are inert.

Register byte addresses (hex), with N = 0 or 1 giving the port:

| Address | Register |
|---|---|
| 00+N | pin input levels (read only) |
| 02+N | output latch |
| 04+N | direction |
| 06+N | open-drain select |
| 08+N | rise enable |
| 0A+N | fall enable |
| 0C+N | level select |
| 0E+N | alert status (write one to clear) |
| 10+N | alert mask |
| 12 | port 0 mux |
| 13 | alert flag, bit 0 (write one to clear) |
| 14 | alert flag mask, bit 0 |

The alert flag state machine has two states:
- **ALR_IDLE**: the flag is clear. The transition ALR_IDLE→ALR_PEND is taken when the summary is high.
- **ALR_PEND**: the flag is set. The transition ALR_PEND→ALR_IDLE is taken on a write of 1 to bit 0 of address 13 while the summary is low. Otherwise the state stays in ALR_PEND.

Top module: `gpio_alert_top`

## Requirements
- R1: While reset is asserted, every readable register reads 0, no pad output is enabled and `alert` is 0. In the full variant, `alt_sel` is 8'hF7 at reset.
- R2: The output latch, direction, open-drain, rise, fall, level, mask and port 0 mux registers read back the value written, limited to implemented bits. The input-level registers ignore writes.
- R3: Direction bit 1 makes a pin an output. With open-drain select 0 (push-pull), an output pin drives its latch value with its enable on. With direction 0, the enable is off.
- R4: With open-drain select 1, an output pin never drives high. Latch 0 drives low with the enable on, and latch 1 turns the enable off.
- R5: The input-level register returns the pad level through a two-flop synchronizer, whatever the pin's direction, two clocks after the pad changes.
- R6: A rise-enabled pin sets its status bit on a synchronized 0→1 transition. A fall-enabled pin sets it on a 1→0 transition. Setting both enables detects either edge, and a pin with only one edge enable ignores the other edge.
- R7: With rise and fall both 0, a pin is in level mode. Level bit 1 sets status while the pin is high, and level bit 0 sets status while it is low.
- R8: Status bits are sticky and are cleared by writing 1. One wide access at address 0E clears both ports. A level condition that still holds re-sets the bit in the same cycle, so setting wins over clearing.
- R9: A status bit reaches the summary only when its mask bit is 1. The summary raises the top alert flag on the next clock. A write of 1 clears the flag only when the summary is low.
- R10: `alert` is high exactly when the alert flag is set and the flag mask bit (address 14, bit 0) is 1.
- R11: A port 0 pin whose mux bit is 1 is under GPIO control. Otherwise `alt_sel` flags it and GPIO does not drive it. In the full variant pin 3 has no mux: it is always GPIO and its mux bit reads 0.
- R12: In the reduced variant only the pins in `RED_MASK` of port 0 exist. Writes to port 1 or to absent pins have no effect, and those bits read 0 and never drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | Access also covers the next byte address |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 16 | Write data; [15:8] goes to address+1 when wide |
| bus_rdata | output | 16 | Read data; [15:8] is zero unless wide |
| pad_in | input | 16 | Pad levels; [7:0] port 0, [15:8] port 1 |
| pad_out | output | 16 | Pad drive value |
| pad_oe | output | 16 | Pad drive enable |
| alt_sel | output | 8 | Port 0 pins owned by their alternate function |
| alert | output | 1 | Summary alert |

## Verification
Two actions can fall on the same clock edge: a write-one-to-clear of a status bit, and the detector setting that same bit again. The bench provokes this by clearing a level-mode pin whose active level is still applied, and by clearing the alert flag while a masked status bit is still set. It judges both by reading the bit back as 1. It then reads it as 0 once the level is removed and the clear is repeated. Random direction, latch, open-drain and pad patterns from a fixed seed check drive and input sampling against bench functions.

// File: rtl/gpio_alert_pkg.sv
package gpio_alert_pkg;
    localparam int NREG     = 8;
    localparam int ADDR_W   = 5;
    localparam int MAP_SIZE = 1 << ADDR_W;

    // Order of per-port registers; port p, register k lives at A_REG_BASE + 2k + p
    typedef enum logic [2:0] {
        RG_DOUT, RG_DIR, RG_OD, RG_RISE, RG_FALL, RG_LVL, RG_STAT, RG_MASK
    } reg_sel_e;

    localparam logic [ADDR_W-1:0] A_DIN      = 5'h00;
    localparam logic [ADDR_W-1:0] A_REG_BASE = 5'h02;
    localparam logic [ADDR_W-1:0] A_MUX      = 5'h12;
    localparam logic [ADDR_W-1:0] A_TOPFLAG  = 5'h13;
    localparam logic [ADDR_W-1:0] A_TOPMASK  = 5'h14;

    typedef enum logic {ALR_IDLE, ALR_PEND} alr_state_e;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port import gpio_alert_pkg::*; #(
    parameter logic [7:0] VMASK = 8'hFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NREG-1:0]       wr_en,
    input  logic [NREG-1:0][7:0]  wr_dat,
    input  logic [7:0]            pad_in,
    output logic [NREG-1:0][7:0]  regs,
    output logic [7:0]            din,
    output logic [7:0]            drv_out,
    output logic [7:0]            drv_oe
);
    logic [NREG-1:0][7:0] regs_q;
    logic [7:0] sync_q, prev_q, hit;
    logic [7:0] dout, dir, od, rise, fall, lvl, clr;

    gpio_sync2 #(.W(8)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pad_in),
        .q    (sync_q)
    );

    assign dout = regs_q[RG_DOUT];
    assign dir  = regs_q[RG_DIR];
    assign od   = regs_q[RG_OD];
    assign rise = regs_q[RG_RISE];
    assign fall = regs_q[RG_FALL];
    assign lvl  = regs_q[RG_LVL];
    assign clr  = wr_en[RG_STAT] ? wr_dat[RG_STAT] : 8'h00;

    // Edge and level detection; level mode only when both edge enables are 0
    always_comb begin
        hit = VMASK & ((rise & sync_q & ~prev_q)
                     | (fall & ~sync_q & prev_q)
                     | (~rise & ~fall & ~(sync_q ^ lvl)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            regs_q <= '0;
        end else begin
            prev_q <= sync_q;
            for (int k = 0; k < NREG; k++) begin
                if (k == int'(RG_STAT))
                    regs_q[k] <= (regs_q[k] & ~clr) | hit;
                else if (wr_en[k])
                    regs_q[k] <= wr_dat[k] & VMASK;
            end
        end
    end

    assign regs    = regs_q;
    assign din     = sync_q & VMASK;
    assign drv_out = dout & ~od & VMASK;
    assign drv_oe  = dir & (~od | ~dout) & VMASK;
endmodule

// File: rtl/gpio_alert_flag.sv
module gpio_alert_flag import gpio_alert_pkg::*; (
    input  logic clk,
    input  logic rst_n,
    input  logic summary,
    input  logic clr,
    output logic flag
);
    alr_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ALR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ALR_IDLE: if (summary)         state_d = ALR_PEND;
            ALR_PEND: if (clr && !summary) state_d = ALR_IDLE;
            default:                       state_d = ALR_IDLE;
        endcase
    end

    always_comb flag = (state_q == ALR_PEND);
endmodule

// File: rtl/gpio_alert_top.sv
module gpio_alert_top import gpio_alert_pkg::*; #(
    parameter bit         REDUCED   = 1'b0,
    parameter logic [7:0] RED_MASK  = 8'h3F,
    parameter int         NOMUX_PIN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic              bus_wide,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic [15:0]       pad_in,
    output logic [15:0]       pad_out,
    output logic [15:0]       pad_oe,
    output logic [7:0]        alt_sel,
    output logic              alert
);
    localparam int         NPORT   = 2;
    localparam logic [7:0] VM0     = REDUCED ? RED_MASK : 8'hFF;
    localparam logic [7:0] VM1     = REDUCED ? 8'h00 : 8'hFF;
    localparam logic [7:0] MUXABLE = REDUCED ? RED_MASK : ~(8'h01 << NOMUX_PIN);
    localparam logic [NPORT-1:0][7:0] VMS = {VM1, VM0};

    logic [ADDR_W-1:0] addr_hi;
    logic              wr;
    logic [NPORT-1:0][NREG-1:0]      we_arr;
    logic [NPORT-1:0][NREG-1:0][7:0] wd_arr;
    logic [NPORT-1:0][NREG-1:0][7:0] regs_arr;
    logic [NPORT-1:0][7:0] din_arr, out_arr, oe_arr;
    logic [7:0]  mux_q;
    logic        topmask_q, flag, flag_clr, summary, stat_wr_any;
    logic [15:0] od_all, stat_all, mask_all, vm_all;
    logic [MAP_SIZE-1:0][7:0] rd_map;

    function automatic logic hit_at(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] lo,
                                    input logic [ADDR_W-1:0] hi, input logic wide);
        return (lo == a) || (wide && (hi == a));
    endfunction

    function automatic logic [7:0] lane(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] lo,
                                        input logic [15:0] d);
        return (lo == a) ? d[7:0] : d[15:8];
    endfunction

    assign addr_hi = bus_addr + 5'd1;
    assign wr      = bus_req && bus_we;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        for (genvar k = 0; k < NREG; k++) begin : g_reg
            localparam logic [ADDR_W-1:0] RA = 5'(int'(A_REG_BASE) + 2 * k + p);
            assign we_arr[p][k] = wr && hit_at(RA, bus_addr, addr_hi, bus_wide);
            assign wd_arr[p][k] = lane(RA, bus_addr, bus_wdata);
        end
        gpio_port #(.VMASK(VMS[p])) u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (we_arr[p]),
            .wr_dat (wd_arr[p]),
            .pad_in (pad_in[8*p +: 8]),
            .regs   (regs_arr[p]),
            .din    (din_arr[p]),
            .drv_out(out_arr[p]),
            .drv_oe (oe_arr[p])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mux_q     <= '0;
            topmask_q <= 1'b0;
        end else begin
            if (wr && hit_at(A_MUX, bus_addr, addr_hi, bus_wide))
                mux_q <= lane(A_MUX, bus_addr, bus_wdata) & MUXABLE;
            if (wr && hit_at(A_TOPMASK, bus_addr, addr_hi, bus_wide))
                topmask_q <= lane(A_TOPMASK, bus_addr, bus_wdata)[0];
        end
    end

    assign flag_clr = wr && hit_at(A_TOPFLAG, bus_addr, addr_hi, bus_wide)
                      && lane(A_TOPFLAG, bus_addr, bus_wdata)[0];

    assign stat_all    = {regs_arr[1][RG_STAT], regs_arr[0][RG_STAT]};
    assign mask_all    = {regs_arr[1][RG_MASK], regs_arr[0][RG_MASK]};
    assign od_all      = {regs_arr[1][RG_OD],   regs_arr[0][RG_OD]};
    assign vm_all      = {VM1, VM0};
    assign summary     = |(stat_all & mask_all);
    assign stat_wr_any = we_arr[0][RG_STAT] || we_arr[1][RG_STAT];

    gpio_alert_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .summary(summary),
        .clr    (flag_clr),
        .flag   (flag)
    );

    assign alert   = flag && topmask_q;
    assign alt_sel = MUXABLE & ~mux_q;
    assign pad_out = {out_arr[1], out_arr[0] & ~alt_sel};
    assign pad_oe  = {oe_arr[1],  oe_arr[0]  & ~alt_sel};

    always_comb begin
        rd_map = '0;
        for (int p = 0; p < NPORT; p++) begin
            rd_map[int'(A_DIN) + p] = din_arr[p];
            for (int k = 0; k < NREG; k++)
                rd_map[int'(A_REG_BASE) + 2 * k + p] = regs_arr[p][k];
        end
        rd_map[A_MUX]     = mux_q;
        rd_map[A_TOPFLAG] = {7'b0, flag};
        rd_map[A_TOPMASK] = {7'b0, topmask_q};
    end

    assign bus_rdata = {bus_wide ? rd_map[addr_hi] : 8'h00, rd_map[bus_addr]};
endmodule

// File: rtl/gpio_alert_chk.sv
module gpio_alert_chk #(
    parameter bit REDUCED   = 1'b0,
    parameter int NOMUX_PIN = 3
) (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] pad_out,
    input logic [15:0] pad_oe,
    input logic [15:0] od_all,
    input logic [15:0] vm_all,
    input logic [15:0] stat_all,
    input logic [7:0]  alt_sel,
    input logic        summary,
    input logic        flag,
    input logic        flag_clr,
    input logic        stat_wr
);
    // R4
    od_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & od_all) == 16'h0000);

    // R12
    absent_pin_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe | stat_all) & ~vm_all) == 16'h0000);

    // R9
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        summary |=> flag);

    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);

    // R8
    stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> ((stat_all & $past(stat_all)) == $past(stat_all)));

    // R11
    nomux_gpio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        REDUCED || !alt_sel[NOMUX_PIN]);
endmodule

bind gpio_alert_top gpio_alert_chk #(.REDUCED(REDUCED), .NOMUX_PIN(NOMUX_PIN)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pad_out (pad_out),
    .pad_oe  (pad_oe),
    .od_all  (od_all),
    .vm_all  (vm_all),
    .stat_all(stat_all),
    .alt_sel (alt_sel),
    .summary (summary),
    .flag    (flag),
    .flag_clr(flag_clr),
    .stat_wr (stat_wr_any)
);

// File: tb/test_gpio_alert_top.sv
`timescale 1ns/100ps
module test_gpio_alert_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_req, bus_we, bus_wide;
    logic [4:0]  bus_addr;
    logic [15:0] bus_wdata, rdata, rdata_r;
    logic [15:0] pad_in, pad_in_r, pad_out, pad_oe, pad_out_r, pad_oe_r;
    logic [7:0]  alt_sel, alt_sel_r;
    logic        alert, alert_r;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;
    logic [15:0] rv, rvr;
    int unsigned seed_init;

    always #2.5 clk = ~clk;

    gpio_alert_top i_gpio_alert_top (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_wide(bus_wide),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .alt_sel(alt_sel), .alert(alert)
    );

    gpio_alert_top #(.REDUCED(1'b1), .RED_MASK(8'h3F)) i_red (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_wide(bus_wide),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_r), .pad_in(pad_in_r),
        .pad_out(pad_out_r), .pad_oe(pad_oe_r), .alt_sel(alt_sel_r), .alert(alert_r)
    );

    function automatic logic [7:0] exp_out(input logic [7:0] dout, input logic [7:0] od);
        return dout & ~od;
    endfunction

    function automatic logic [7:0] exp_oe(input logic [7:0] dout, input logic [7:0] dir,
                                          input logic [7:0] od);
        return dir & (~od | ~dout);
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d, input logic w);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_wide = w;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0; bus_wide = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic w,
                      output logic [15:0] d, output logic [15:0] dr);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_wide = w;
        #1;
        d = rdata; dr = rdata_r;
        bus_req = 1'b0; bus_wide = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0; bus_wide = 1'b0;
        bus_addr = '0; bus_wdata = '0; pad_in = '0; pad_in_r = '0;
        seed_init = $urandom(32'd20191119);
        tick(3);

        // R1: reset values, read while reset is held
        for (int a = 2; a <= 16; a += 2) begin
            if (a == 14) continue;
            rd(5'(a), 1'b1, rv, rvr);
            chk($sformatf("R1 reset reg %0h", a), rv, 16'h0000);
        end
        rd(5'h12, 1'b1, rv, rvr); chk("R1 reset mux/flag", rv, 16'h0000);
        rd(5'h14, 1'b0, rv, rvr); chk("R1 reset flag mask", rv, 16'h0000);
        chk("R1 reset pad_oe", pad_oe, 16'h0000);
        chk("R1 reset alert", {15'b0, alert}, 16'h0000);
        chk("R1 reset alt_sel", {8'h00, alt_sel}, 16'h00F7);
        chk("R1 reduced reset alt_sel", {8'h00, alt_sel_r}, 16'h003F);
        rst_n = 1'b1;

        // Level-high mode everywhere with pads low: no status
        wr(5'h0C, 16'hFFFF, 1'b1);
        tick(3);
        wr(5'h0E, 16'hFFFF, 1'b1);
        rd(5'h0E, 1'b1, rv, rvr); chk("R7 level-high, pads low, no status", rv, 16'h0000);
        rd(5'h0C, 1'b1, rv, rvr); chk("R2 level readback", rv, 16'hFFFF);

        // R11: mux gating of port 0
        wr(5'h02, 16'h00FF, 1'b0);
        wr(5'h04, 16'h00FF, 1'b0);
        chk("R11 unmuxed pins not driven", {8'h00, pad_oe[7:0]}, 16'h0008);
        wr(5'h12, 16'h00FF, 1'b0);
        rd(5'h12, 1'b0, rv, rvr); chk("R11 mux bit 3 reads 0", rv, 16'h00F7);
        chk("R11 all port0 pins GPIO", {8'h00, alt_sel}, 16'h0000);
        chk("R11 port0 driven after mux", {8'h00, pad_oe[7:0]}, 16'h00FF);

        // R12: reduced variant
        chk("R12 reduced mux", {8'h00, alt_sel_r}, 16'h0000);
        chk("R12 reduced port0 oe", {8'h00, pad_oe_r[7:0]}, 16'h003F);
        chk("R12 reduced dir0 readback", rvr, rvr);
        rd(5'h04, 1'b0, rv, rvr); chk("R12 reduced dir0 masked", rvr, 16'h003F);
        wr(5'h03, 16'h00FF, 1'b0);
        wr(5'h05, 16'h00FF, 1'b0);
        chk("R12 reduced port1 no drive", {8'h00, pad_oe_r[15:8]}, 16'h0000);
        chk("R3 full port1 drives", {8'h00, pad_oe[15:8]}, 16'h00FF);
        rd(5'h05, 1'b0, rv, rvr); chk("R12 reduced dir1 reads 0", rvr, 16'h0000);
        pad_in_r = 16'hFFFF;
        tick(3);
        rd(5'h00, 1'b1, rv, rvr); chk("R12 reduced din limited", rvr, 16'h003F);
        pad_in_r = 16'h0000;

        // R2-R5: random drive configurations and pad patterns
        for (int it = 0; it < 24; it++) begin
            int p;
            logic [7:0] d_o, d_r, o_d;
            logic [15:0] pv;
            p   = int'($urandom % 2);
            d_o = 8'($urandom); d_r = 8'($urandom); o_d = 8'($urandom);
            if (it == 0) begin d_o = 8'hF0; d_r = 8'hFF; o_d = 8'hCC; end
            wr(5'(2 + p), {8'h00, d_o}, 1'b0);
            wr(5'(4 + p), {8'h00, d_r}, 1'b0);
            wr(5'(6 + p), {8'h00, o_d}, 1'b0);
            chk($sformatf("R3 R4 pad_out port%0d", p), {8'h00, pad_out[8*p +: 8]},
                {8'h00, exp_out(d_o, o_d)});
            chk($sformatf("R3 R4 pad_oe port%0d", p), {8'h00, pad_oe[8*p +: 8]},
                {8'h00, exp_oe(d_o, d_r, o_d)});
            rd(5'(6 + p), 1'b0, rv, rvr); chk("R2 od readback", rv, {8'h00, o_d});
            pv = 16'($urandom);
            pad_in = pv;
            tick(3);
            rd(5'h00, 1'b1, rv, rvr); chk("R5 din follows pad", rv, pv);
            wr(5'h00, 16'h0000, 1'b1);
            rd(5'h00, 1'b1, rv, rvr); chk("R2 din ignores writes", rv, pv);
        end

        pad_in = 16'h0000;
        tick(3);
        wr(5'h0E, 16'hFFFF, 1'b1);
        rd(5'h0E, 1'b1, rv, rvr); chk("R8 wide clear both ports", rv, 16'h0000);

        // R6: edge alerts on port 1 pin 2
        wr(5'h09, 16'h0004, 1'b0);
        pad_in[10] = 1'b1; tick(4);
        rd(5'h0F, 1'b0, rv, rvr); chk("R6 rise sets status", rv, 16'h0004);
        wr(5'h0F, 16'h0004, 1'b0);
        rd(5'h0F, 1'b0, rv, rvr); chk("R8 edge status cleared", rv, 16'h0000);
        pad_in[10] = 1'b0; tick(4);
        rd(5'h0F, 1'b0, rv, rvr); chk("R6 rise-only ignores fall", rv, 16'h0000);
        wr(5'h0B, 16'h0004, 1'b0);
        pad_in[10] = 1'b1; tick(4);
        rd(5'h0F, 1'b0, rv, rvr); chk("R6 both edges: rise", rv, 16'h0004);
        wr(5'h0F, 16'h0004, 1'b0);
        pad_in[10] = 1'b0; tick(4);
        rd(5'h0F, 1'b0, rv, rvr); chk("R6 both edges: fall", rv, 16'h0004);
        wr(5'h09, 16'h0000, 1'b1);
        wr(5'h0F, 16'h0004, 1'b0);

        // R7-R10: level-high on port 0 pin 5, mask and alert path
        pad_in[5] = 1'b1; tick(4);
        rd(5'h0E, 1'b0, rv, rvr); chk("R7 level-high sets status", rv, 16'h0020);
        rd(5'h13, 1'b0, rv, rvr); chk("R9 unmasked status no flag", rv, 16'h0000);
        wr(5'h0E, 16'h0020, 1'b0);
        rd(5'h0E, 1'b0, rv, rvr); chk("R8 set wins over clear", rv, 16'h0020);
        wr(5'h10, 16'h0020, 1'b0);
        tick(1);
        rd(5'h13, 1'b0, rv, rvr); chk("R9 masked status raises flag", rv, 16'h0001);
        chk("R10 alert off without flag mask", {15'b0, alert}, 16'h0000);
        wr(5'h14, 16'h0001, 1'b0);
        chk("R10 alert with flag mask", {15'b0, alert}, 16'h0001);
        wr(5'h13, 16'h0001, 1'b0);
        rd(5'h13, 1'b0, rv, rvr); chk("R9 flag held while summary high", rv, 16'h0001);
        pad_in[5] = 1'b0; tick(4);
        wr(5'h0E, 16'hFFFF, 1'b1);
        rd(5'h0E, 1'b1, rv, rvr); chk("R8 clear after level gone", rv, 16'h0000);
        wr(5'h13, 16'h0001, 1'b0);
        rd(5'h13, 1'b0, rv, rvr); chk("R9 flag cleared", rv, 16'h0000);
        chk("R10 alert drops", {15'b0, alert}, 16'h0000);

        // R7: level-low on port 1 pin 6
        wr(5'h0D, 16'h00BF, 1'b0);
        tick(3);
        rd(5'h0F, 1'b0, rv, rvr); chk("R7 level-low sets status", rv, 16'h0040);
        pad_in[14] = 1'b1; tick(4);
        wr(5'h0F, 16'h0040, 1'b0);
        rd(5'h0F, 1'b0, rv, rvr); chk("R7 level-low inactive when high", rv, 16'h0000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule